// File: doc/BRIEF.md
# Root Hub Status Register Bank

This block holds the status registers for the root hub of a two-port USB host controller: one hub-wide word and one status/change word per downstream port. Software reaches them over a plain 32-bit register bus (byte address, write strobe, write data, combinational read data). The hub word reports the hub overcurrent condition and carries a write-only command that drops port power on every port that is not masked. Each port word shows live connect and power-present levels, a port power flag, and sticky change flags that software clears by writing ones.

Change-flag clears that software issues while a bus transaction (token through handshake) is in flight are not applied at once. Each port parks the latest such write in a single pending slot and applies it on the first clock after the transaction flag drops. The controller's USB-reset state wipes all port state, and the asynchronous active-low reset is released to the logic through a two-stage synchronizer.

Top module: `rh_status_bank`

## Requirements
- R1: After reset the port power flag (bit 8) and the change flags (bits 16 and 17) of both port words read 0. Logic leaves reset on the third rising clock edge after rst_n rises.
- R2: The hub word is at byte address 0x50, port 0 at 0x54 and port 1 at 0x58. Any other address reads 0 and a write to it changes nothing.
- R3: Hub word bit 1 reads 1 while hub_oc_in is 1 and oc_per_port is 0. It reads 0 whenever oc_per_port is 1.
- R4: Hub word bit 0 always reads 0. Every bit of a word other than hub bit 1 and port bits 0, 1, 8, 16 and 17 reads 0, and writes to those bits have no effect.
- R5: Writing 1 to bit 0 of the hub word clears, at that clock edge, the port power flag of every port whose pwr_mask bit is 0. Ports whose mask bit is 1 keep their flag. Writing 0 to that bit does nothing.
- R6: Writing 1 to bit 8 of a port word sets that port's power flag. Writing 0 to it has no effect.
- R7: Port word bit 0 follows conn_in and bit 1 follows pwr_in of that port with no delay.
- R8: Bit 16 of a port word sets on any change of conn_in, and bit 17 on any change of pwr_in. The flag is visible after the first rising edge that sees the new level.
- R9: Writing 1 to bit 16 or 17 of a port word while xfer_busy is 0 clears that flag. A change event in the same cycle wins over the clear, and writing 0 does nothing.
- R10: A change-flag clear written while xfer_busy is 1 leaves the flags untouched. It is held, and a newer write to the same port replaces it. It is applied at the first rising edge at which xfer_busy is 0.
- R11: While usb_reset is 1, both ports' power flags, change flags and pending clears are cleared at each edge. The hub word is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one write per cycle held high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| hub_oc_in | input | 1 | Hub-wide overcurrent condition |
| oc_per_port | input | 1 | 1 when overcurrent protection is done per port |
| conn_in | input | 2 | Per-port connect level |
| pwr_in | input | 2 | Per-port power-present level |
| pwr_mask | input | 2 | Per-port power control mask, 1 shields from global clear |
| xfer_busy | input | 1 | Transaction in progress, token to handshake |
| usb_reset | input | 1 | Controller is in its USB-reset state |

## Verification
The bench aims at the cycles where two rules meet. A change event lands in the same cycle as a clear of that flag: a design that lets the clear win loses the event. The transaction flag is high while two successive clears are written: a design that applies the clear early, merges both writes instead of keeping the newer one, or never applies it shows a flag level that differs from the model. Global power clear is issued with mixed mask bits, which catches a design that ignores or inverts the mask. USB reset is asserted with a clear still pending, so a design that keeps the stale pending write clears a flag set after the reset.

// File: rtl/rh_pkg.sv
package rh_pkg;
  localparam int unsigned HUB_OFS     = 32'h50;
  localparam int unsigned PORT_BASE   = 32'h54;
  localparam int unsigned PORT_STRIDE = 4;
  localparam int unsigned NMON        = 2;
  localparam int unsigned HUB_GCLR    = 0;
  localparam int unsigned HUB_OCI     = 1;
  localparam int unsigned PS_CONN     = 0;
  localparam int unsigned PS_PWRIN    = 1;
  localparam int unsigned PS_PPS      = 8;
  localparam int unsigned CHG_LSB     = 16;
  typedef logic [NMON-1:0] mon_t;
endpackage

// File: rtl/rh_rst_sync.sv
module rh_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rh_hub_reg.sv
module rh_hub_reg import rh_pkg::*; #(
  parameter int unsigned DW = 32
) (
  input  logic          hub_wr,
  input  logic          gclr_bit,
  input  logic          hub_oc_in,
  input  logic          oc_per_port,
  output logic          gclr,
  output logic [DW-1:0] hub_word
);
  always_comb begin
    hub_word          = '0;
    hub_word[HUB_OCI] = hub_oc_in & ~oc_per_port;
    hub_word[HUB_GCLR] = 1'b0;
    gclr              = hub_wr & gclr_bit;
  end
endmodule

// File: rtl/rh_port_reg.sv
module rh_port_reg import rh_pkg::*; #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_wr,
  input  logic          set_pps,
  input  mon_t          clr_req,
  input  logic          conn_in,
  input  logic          pwr_in,
  input  logic          pwr_mask,
  input  logic          gclr,
  input  logic          xfer_busy,
  input  logic          usb_reset,
  output logic          pps_o,
  output mon_t          chg_o,
  output logic [DW-1:0] port_word
);
  mon_t mon, ev, clr;
  mon_t prev_q, chg_q, chg_d, pend_q, pend_d;
  logic pps_q, pps_d, pend_v_q, pend_v_d;
  logic chg_en, pps_en;

  always_comb begin
    mon      = {pwr_in, conn_in};
    ev       = mon ^ prev_q;
    clr      = '0;
    pend_v_d = pend_v_q;
    pend_d   = pend_q;
    if (port_wr && xfer_busy) begin
      pend_v_d = 1'b1;
      pend_d   = clr_req;
    end else begin
      if (port_wr) clr = clr_req;
      if (!xfer_busy && pend_v_q) begin
        clr      = clr | pend_q;
        pend_v_d = 1'b0;
        pend_d   = '0;
      end
    end
    chg_d = ev | (chg_q & ~clr);
    pps_d = pps_q;
    if (port_wr && set_pps)   pps_d = 1'b1;
    else if (gclr && !pwr_mask) pps_d = 1'b0;
    if (usb_reset) begin
      chg_d    = '0;
      pps_d    = 1'b0;
      pend_v_d = 1'b0;
      pend_d   = '0;
    end
    chg_en = usb_reset | port_wr | pend_v_q | (|ev);
    pps_en = usb_reset | port_wr | gclr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      chg_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      pps_q    <= 1'b0;
    end else begin
      prev_q <= mon;
      if (chg_en) begin
        chg_q    <= chg_d;
        pend_q   <= pend_d;
        pend_v_q <= pend_v_d;
      end
      if (pps_en) pps_q <= pps_d;
    end
  end

  always_comb begin
    port_word                    = '0;
    port_word[PS_CONN]           = conn_in;
    port_word[PS_PWRIN]          = pwr_in;
    port_word[PS_PPS]            = pps_q;
    port_word[CHG_LSB +: NMON]   = chg_q;
  end

  assign pps_o = pps_q;
  assign chg_o = chg_q;
endmodule

// File: rtl/rh_read_mux.sv
module rh_read_mux import rh_pkg::*; #(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DW     = 32
) (
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DW-1:0]              hub_word,
  input  logic [NPORTS-1:0][DW-1:0]  port_words,
  output logic [DW-1:0]              reg_rdata
);
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(HUB_OFS)) reg_rdata = hub_word;
    for (int i = 0; i < NPORTS; i++) begin
      if (reg_addr == ADDR_W'(PORT_BASE + PORT_STRIDE * i)) reg_rdata = port_words[i];
    end
  end
endmodule

// File: rtl/rh_status_bank.sv
module rh_status_bank import rh_pkg::*; #(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              hub_oc_in,
  input  logic              oc_per_port,
  input  logic [NPORTS-1:0] conn_in,
  input  logic [NPORTS-1:0] pwr_in,
  input  logic [NPORTS-1:0] pwr_mask,
  input  logic              xfer_busy,
  input  logic              usb_reset
);
  logic                      rst_sync_n;
  logic                      hub_wr, gclr;
  logic [DW-1:0]             hub_word;
  logic [NPORTS-1:0][DW-1:0] port_words;
  logic [NPORTS-1:0]         pps_vec;
  mon_t [NPORTS-1:0]         chg_vec;
  logic                      wdata_unused;

  assign wdata_unused = ^reg_wdata;
  assign hub_wr       = reg_wr && (reg_addr == ADDR_W'(HUB_OFS));

  rh_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_sync_n)
  );

  rh_hub_reg #(.DW(DW)) u_hub (
    .hub_wr(hub_wr), .gclr_bit(reg_wdata[HUB_GCLR]),
    .hub_oc_in(hub_oc_in), .oc_per_port(oc_per_port),
    .gclr(gclr), .hub_word(hub_word)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic port_wr;
    assign port_wr = reg_wr && (reg_addr == ADDR_W'(PORT_BASE + PORT_STRIDE * p));
    rh_port_reg #(.DW(DW)) u_port (
      .clk(clk), .rst_n(rst_sync_n), .port_wr(port_wr),
      .set_pps(reg_wdata[PS_PPS]), .clr_req(reg_wdata[CHG_LSB +: NMON]),
      .conn_in(conn_in[p]), .pwr_in(pwr_in[p]), .pwr_mask(pwr_mask[p]),
      .gclr(gclr), .xfer_busy(xfer_busy), .usb_reset(usb_reset),
      .pps_o(pps_vec[p]), .chg_o(chg_vec[p]), .port_word(port_words[p])
    );
  end

  rh_read_mux #(.NPORTS(NPORTS), .ADDR_W(ADDR_W), .DW(DW)) u_mux (
    .reg_addr(reg_addr), .hub_word(hub_word),
    .port_words(port_words), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/rh_status_checker.sv
module rh_status_checker import rh_pkg::*; #(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DW     = 32
) (
  input logic                    clk,
  input logic                    rst_i,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic                    reg_wr,
  input logic [DW-1:0]           reg_wdata,
  input logic [DW-1:0]           reg_rdata,
  input logic [NPORTS-1:0]       conn_in,
  input logic [NPORTS-1:0]       pwr_mask,
  input logic                    xfer_busy,
  input logic                    usb_reset,
  input logic [NPORTS-1:0]       pps_q,
  input mon_t [NPORTS-1:0]       chg_q
);
  function automatic logic [DW-1:0] legal_bits(logic [ADDR_W-1:0] a);
    logic [DW-1:0] m;
    m = '0;
    if (a == ADDR_W'(HUB_OFS)) m[HUB_OCI] = 1'b1;
    for (int i = 0; i < NPORTS; i++) begin
      if (a == ADDR_W'(PORT_BASE + PORT_STRIDE * i)) begin
        m[PS_CONN] = 1'b1; m[PS_PWRIN] = 1'b1; m[PS_PPS] = 1'b1;
        m[CHG_LSB +: NMON] = '1;
      end
    end
    return m;
  endfunction

  logic hub_gclr;
  assign hub_gclr = reg_wr && (reg_addr == ADDR_W'(HUB_OFS)) && reg_wdata[HUB_GCLR];

  p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_rdata & ~legal_bits(reg_addr)) == '0);

  p_usb_wipe_r11: assert property (@(posedge clk) disable iff (!rst_i)
    usb_reset |=> (pps_q == '0 && chg_q == '0));

  for (genvar i = 0; i < NPORTS; i++) begin : g_chk
    p_gclr_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_i)
      (hub_gclr && !pwr_mask[i]) |=> !pps_q[i]);

    p_gclr_masked_r5: assert property (@(posedge clk) disable iff (!rst_i)
      (hub_gclr && pwr_mask[i] && !usb_reset) |=> pps_q[i] == $past(pps_q[i]));

    p_conn_event_r8: assert property (@(posedge clk) disable iff (!rst_i)
      ($past(rst_i) && !usb_reset && conn_in[i] != $past(conn_in[i])) |=> chg_q[i][0]);

    for (genvar j = 0; j < NMON; j++) begin : g_bit
      p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_i)
        (xfer_busy && !usb_reset && chg_q[i][j]) |=> chg_q[i][j]);
    end
  end
endmodule

bind rh_status_bank rh_status_checker #(.NPORTS(NPORTS), .ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst_i(rst_sync_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conn_in(conn_in),
  .pwr_mask(pwr_mask), .xfer_busy(xfer_busy), .usb_reset(usb_reset),
  .pps_q(pps_vec), .chg_q(chg_vec)
);

// File: tb/tb_rh_status_bank.sv
`timescale 1ns/1ps
module tb_rh_status_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        hub_oc, oc_pp, busy, usbr;
  logic [1:0]  conn, pwr, mask;

  int    n_chk = 0;
  int    n_fail = 0;
  int    rcnt = 0;
  string cur_req = "R1";

  bit       m_pps[2];
  bit [1:0] m_flg[2];
  bit [1:0] m_pend[2];
  bit       m_pv[2];
  bit [1:0] m_prev[2];

  always #10 clk = ~clk;

  rh_status_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
    .reg_rdata(rdata), .hub_oc_in(hub_oc), .oc_per_port(oc_pp), .conn_in(conn),
    .pwr_in(pwr), .pwr_mask(mask), .xfer_busy(busy), .usb_reset(usbr)
  );

  task automatic m_clear();
    for (int p = 0; p < 2; p++) begin
      m_pps[p] = 0; m_flg[p] = 0; m_pend[p] = 0; m_pv[p] = 0; m_prev[p] = 0;
    end
  endtask

  task automatic m_step();
    for (int p = 0; p < 2; p++) begin
      bit [1:0] now_in, clr;
      bit       pw;
      now_in = {pwr[p], conn[p]};
      pw     = wr && (addr == 8'h54 + 8'(4 * p));
      if (usbr) begin
        m_pps[p] = 0; m_flg[p] = 0; m_pend[p] = 0; m_pv[p] = 0;
      end else begin
        clr = 0;
        if (pw && busy) begin
          m_pend[p] = wdata[17:16]; m_pv[p] = 1;
        end else begin
          if (pw) clr = wdata[17:16];
          if (!busy && m_pv[p]) begin clr |= m_pend[p]; m_pv[p] = 0; m_pend[p] = 0; end
        end
        m_flg[p] = (now_in ^ m_prev[p]) | (m_flg[p] & ~clr);
        if (pw && wdata[8]) m_pps[p] = 1;
        else if (wr && addr == 8'h50 && wdata[0] && !mask[p]) m_pps[p] = 0;
      end
      m_prev[p] = now_in;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt = 0; m_clear();
    end else begin
      if (rcnt < 3) rcnt++;
      if (rcnt < 3) m_clear();
      else m_step();
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] r;
    r = 0;
    if (a == 8'h50) r[1] = hub_oc & ~oc_pp;
    for (int p = 0; p < 2; p++) begin
      if (a == 8'h54 + 8'(4 * p)) begin
        r[0] = conn[p]; r[1] = pwr[p]; r[8] = m_pps[p]; r[17:16] = m_flg[p];
      end
    end
    return r;
  endfunction

  task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d);
    logic [31:0] exp_v;
    @(negedge clk);
    addr = a; wr = w; wdata = d;
    #1;
    exp_v = m_read(addr);
    n_chk++;
    if (rdata !== exp_v) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%h expected=%h", cur_req, addr, rdata, exp_v);
    end
  endtask

  task automatic rd(input logic [7:0] a);
    step(a, 1'b0, 32'h0);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; addr = 8'h50; wr = 0; wdata = 0; hub_oc = 0; oc_pp = 0;
    busy = 0; usbr = 0; conn = 0; pwr = 0; mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state of all words
    cur_req = "R1";
    repeat (4) rd(8'h50);
    rd(8'h54); rd(8'h58);
    // R2: address map and unmapped addresses
    cur_req = "R2";
    rd(8'h5C); rd(8'h00); rd(8'h52); rd(8'h4C);
    step(8'h60, 1, 32'hFFFF_FFFF); rd(8'h54); rd(8'h58);
    // R3: overcurrent indicator gating
    cur_req = "R3";
    hub_oc = 1; rd(8'h50); oc_pp = 1; rd(8'h50); oc_pp = 0; rd(8'h50);
    hub_oc = 0; rd(8'h50);
    // R7 and R8: live levels and change capture
    cur_req = "R7";
    conn[0] = 1; rd(8'h54);
    cur_req = "R8";
    rd(8'h54); rd(8'h54);
    pwr[1] = 1; rd(8'h58); rd(8'h58); conn[1] = 1; rd(8'h58); rd(8'h58);
    // R9: write-one-to-clear and set priority
    cur_req = "R9";
    step(8'h54, 1, 32'h0000_0000); rd(8'h54);
    step(8'h54, 1, 32'h0001_0000); rd(8'h54);
    conn[0] = 0; step(8'h54, 1, 32'h0001_0000); rd(8'h54); rd(8'h54);
    step(8'h58, 1, 32'h0003_0000); rd(8'h58);
    // R6: set port power
    cur_req = "R6";
    step(8'h54, 1, 32'h0000_0000); rd(8'h54);
    step(8'h54, 1, 32'h0000_0100); rd(8'h54);
    step(8'h58, 1, 32'h0000_0100); rd(8'h58);
    // R5: global clear honours mask
    cur_req = "R5";
    mask = 2'b10;
    step(8'h50, 1, 32'h0000_0000); rd(8'h54); rd(8'h58);
    step(8'h50, 1, 32'h0000_0001); rd(8'h54); rd(8'h58);
    step(8'h54, 1, 32'h0000_0100); mask = 2'b01;
    step(8'h50, 1, 32'h0000_0001); rd(8'h54); rd(8'h58);
    mask = 2'b00;
    // R4: reserved bits and hub bit 0
    cur_req = "R4";
    step(8'h50, 1, 32'hFFFF_FFFE); rd(8'h50); rd(8'h54);
    step(8'h58, 1, 32'hFFFC_FEFC); rd(8'h58);
    // R10: deferred clears during a transaction
    cur_req = "R10";
    conn[0] = 1; pwr[0] = 1; rd(8'h54); rd(8'h54);
    busy = 1;
    step(8'h54, 1, 32'h0001_0000); rd(8'h54); rd(8'h54);
    step(8'h54, 1, 32'h0002_0000); rd(8'h54); rd(8'h54);
    busy = 0; rd(8'h54); rd(8'h54);
    busy = 1; step(8'h58, 1, 32'h0003_0000); busy = 0;
    step(8'h58, 1, 32'h0000_0000); rd(8'h58);
    // R11: USB reset wipes port state with a clear pending
    cur_req = "R11";
    step(8'h54, 1, 32'h0000_0100); busy = 1;
    step(8'h54, 1, 32'h0001_0000); usbr = 1; rd(8'h54); rd(8'h54);
    usbr = 0; busy = 0; conn[0] = 0; rd(8'h54); rd(8'h54); rd(8'h58); rd(8'h50);
    // R9: mixed traffic against the model
    cur_req = "R9";
    for (int k = 0; k < 600; k++) begin
      int sel;
      sel = $urandom % 4;
      conn   = ($urandom % 5 == 0) ? ~conn : conn;
      pwr    = ($urandom % 7 == 0) ? pwr ^ 2'($urandom) : pwr;
      busy   = ($urandom % 3 == 0);
      usbr   = ($urandom % 40 == 0);
      mask   = 2'($urandom);
      hub_oc = ($urandom % 2 == 0);
      oc_pp  = ($urandom % 4 == 0);
      step(sel == 0 ? 8'h50 : (sel == 1 ? 8'h54 : 8'h58), ($urandom % 3 == 0), $urandom);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule